// File: doc/BRIEF.md
# BCD Calendar Timekeeping Core

This core keeps the time of day and the calendar as seven packed-BCD byte registers: seconds, minutes, hours, weekday, day of month, month and two-digit year. A free-running 32.768 kHz clock-enable input feeds a prescaler. Each time the prescaler wraps, it sends a one-second advance to the counters. The prescaler's upper half-period is also brought out as a 1 Hz phase reference for a neighbouring square-wave generator. The counters advance on the falling edge of that reference.

Software or a serial front end writes the registers through a byte-wide port. A separate read port returns the live counter values. A bus interface reads instead from a shadow bank, which it refreshes with a single-cycle start pulse. A multi-byte read therefore sees one coherent instant while the counters keep running. The hours byte holds a 12/24-hour selector. The seconds byte holds a halt flag that freezes both the prescaler and the counters.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the registers read, by address, 0:0x80 (halt set, 00 s), 1:0x00, 2:0x00 (24-hour, 00 h), 3:0x01, 4:0x01, 5:0x01, 6:0x00.
- R2: Seconds (address 0, bits 6:0) and minutes (address 1) count 00..59 in BCD. Passing 59 returns the field to 00 and carries one into the next field.
- R3: With hours bit 6 clear, the hours byte counts 00..23 in BCD. Passing 23 returns it to 00 and advances the day.
- R4: With hours bit 6 set, bit 5 is PM and bits 4:0 count 01..12. Hour 11 becomes 12 and toggles PM. Hour 12 becomes 01 with PM unchanged. The day advances only when 11 PM becomes 12 AM.
- R5: While address 0 bit 7 is 1, neither the prescaler nor any counter changes. Writing it back to 0 resumes counting.
- R6: With DIV clock enables per second, any write to address 0 clears the prescaler. The next advance comes on exactly the DIV-th following enable. The phase output is high while the prescaler is in its upper half.
- R7: The day of month (address 4) wraps to 01 after 30 in months 04, 06, 09 and 11, after 31 in the other months, and after 28 in February. In February of a year divisible by 4 it wraps after 29. Each wrap advances the month.
- R8: The weekday (address 3) advances with each day and goes from 7 back to 1.
- R9: The month (address 5) goes from 12 to 01 and advances the year. The year (address 6) goes from 99 to 00.
- R10: A bus-start pulse copies all seven live bytes into the shadow bank on the next edge. The shadow bank holds its value at all other times.
- R11: Bits with no field read 0 and ignore writes: bit 7 of addresses 1, 2, 4 and 5, bits 7:3 of address 3, bits 7:6 of address 4, and bits 7:5 of address 5.
- R12: Address 7 reads 0x00 on both ports, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle enable at 32.768 kHz |
| wr_en | input | 1 | Register write strobe (applies at the byte acknowledge) |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Live read address |
| rd_data | output | 8 | Live register byte |
| bus_start | input | 1 | Shadow reload pulse, one per bus start condition |
| shd_addr | input | 3 | Shadow read address |
| shd_data | output | 8 | Shadow register byte |
| sec_phase | output | 1 | 1 Hz phase reference; counters advance on its falling edge |
| sec_tick | output | 1 | One-cycle pulse in the cycle the counters advance |

## Verification
The hardest situation to reach from the ports is a cascade of carries that runs through every field at once, such as 23:59:59 on the last day of a month. Waiting for it by counting would take millions of seconds. The stimulus therefore writes the fields directly while no clock enables arrive. It then writes the seconds, which restarts the prescaler, and issues exactly one second of enables. A small prescaler divisor keeps each second short. Leap February, 30-day months, the year wrap and the midnight crossing in 12-hour mode each get their own preset.

// File: rtl/rtc_pkg.sv
// Package rtc_pkg: shared constants and BCD helper functions for the
// calendar timekeeping core. Assumes well-formed BCD inputs.
package rtc_pkg;
    localparam int unsigned RTC_NREGS = 7;
    localparam int unsigned RTC_AW    = 3;
    localparam int unsigned RTC_FLATW = 8 * RTC_NREGS;

    // Register addresses; the order is fixed by the decode of the neighbours.
    localparam logic [RTC_AW-1:0] RA_SEC  = 3'd0;
    localparam logic [RTC_AW-1:0] RA_MIN  = 3'd1;
    localparam logic [RTC_AW-1:0] RA_HR   = 3'd2;
    localparam logic [RTC_AW-1:0] RA_DOW  = 3'd3;
    localparam logic [RTC_AW-1:0] RA_DATE = 3'd4;
    localparam logic [RTC_AW-1:0] RA_MON  = 3'd5;
    localparam logic [RTC_AW-1:0] RA_YR   = 3'd6;

    // Power-on image, byte 6 in the top bits down to byte 0.
    localparam logic [RTC_FLATW-1:0] RTC_RESET_FLAT =
        {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h80};

    // Add one to a two-digit BCD value (no range wrap).
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Divisible-by-4 test; arg is {tens[0], units}. Valid for 2000..2099.
    function automatic logic bcd_leap(input logic [4:0] y);
        if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
        return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    endfunction

    // Last day of a BCD month.
    function automatic logic [5:0] month_last(input logic [4:0] m, input logic lp);
        case (m)
            5'h02:                      return lp ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                    return 6'h31;
        endcase
    endfunction
endpackage

// File: rtl/rtc_prescaler.sv
// rtc_prescaler: divides the clock-enable stream by DIV to make the
// one-second advance. Assumes DIV >= 2. The phase output is high in
// the upper half of the count, so each wrap is a falling edge of phase.
module rtc_prescaler #(
    parameter int unsigned DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic halt,
    input  logic clr,
    output logic sec_tick,
    output logic phase
);
    localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);
    localparam logic [CW-1:0] HALF = CW'(DIV / 2);

    logic [CW-1:0] cnt_q;

    // Sub-second counter: cleared by a seconds write, frozen while halted.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (clr)            cnt_q <= '0;
        else if (ce && !halt)    cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    assign sec_tick = ce && !halt && !clr && (cnt_q == LAST);
    assign phase    = (cnt_q >= HALF);
endmodule

// File: rtl/rtc_calendar.sv
// rtc_calendar: the BCD time and date counters with their write port.
// Assumes the software loads legal BCD values. A write in the same
// cycle as an advance takes priority for the field it addresses.
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic                  wr_en,
    input  logic [RTC_AW-1:0]     wr_addr,
    input  logic [7:0]            wr_data,
    output logic                  halt,
    output logic [RTC_FLATW-1:0]  live_flat
);
    logic       halt_q;
    logic [6:0] sec_q, min_q, hr_q;
    logic [2:0] dow_q;
    logic [5:0] date_q;
    logic [4:0] mon_q;
    logic [7:0] yr_q;

    logic [6:0] sec_n, min_n, hr_n;
    logic [2:0] dow_n;
    logic [5:0] date_n;
    logic [4:0] mon_n;
    logic [7:0] yr_n;

    logic [6:0] sec_inc, min_inc;
    logic [5:0] hr24_inc, date_inc;
    logic [4:0] hr12_inc, mon_inc;
    logic [7:0] yr_inc;
    logic       is_leap;
    logic [5:0] last_day;

    assign sec_inc  = 7'(bcd_inc({1'b0, sec_q}));
    assign min_inc  = 7'(bcd_inc({1'b0, min_q}));
    assign hr24_inc = 6'(bcd_inc({2'b0, hr_q[5:0]}));
    assign hr12_inc = 5'(bcd_inc({3'b0, hr_q[4:0]}));
    assign date_inc = 6'(bcd_inc({2'b0, date_q}));
    assign mon_inc  = 5'(bcd_inc({3'b0, mon_q}));
    assign yr_inc   = bcd_inc(yr_q);
    assign is_leap  = bcd_leap({yr_q[4], yr_q[3:0]});
    assign last_day = month_last(mon_q, is_leap);

    // Next-state chain: each field rolls over and carries into the next.
    always_comb begin
        logic c_min, c_hr, c_day, c_mon, c_yr;
        sec_n = sec_q; min_n = min_q; hr_n = hr_q; dow_n = dow_q;
        date_n = date_q; mon_n = mon_q; yr_n = yr_q;
        c_min = 1'b0; c_hr = 1'b0; c_day = 1'b0; c_mon = 1'b0; c_yr = 1'b0;
        if (tick) begin
            if (sec_q == 7'h59) begin sec_n = 7'h00; c_min = 1'b1; end
            else                       sec_n = sec_inc;
        end
        if (c_min) begin
            if (min_q == 7'h59) begin min_n = 7'h00; c_hr = 1'b1; end
            else                       min_n = min_inc;
        end
        if (c_hr) begin
            if (!hr_q[6]) begin
                if (hr_q[5:0] == 6'h23) begin hr_n = 7'h00; c_day = 1'b1; end
                else                          hr_n = {1'b0, hr24_inc};
            end else begin
                if (hr_q[4:0] == 5'h12)      hr_n = {1'b1, hr_q[5], 5'h01};
                else if (hr_q[4:0] == 5'h11) begin
                    hr_n  = {1'b1, ~hr_q[5], 5'h12};
                    c_day = hr_q[5];
                end else                     hr_n = {1'b1, hr_q[5], hr12_inc};
            end
        end
        if (c_day) begin
            dow_n = (dow_q == 3'd7) ? 3'd1 : dow_q + 3'd1;
            if (date_q == last_day) begin date_n = 6'h01; c_mon = 1'b1; end
            else                          date_n = date_inc;
        end
        if (c_mon) begin
            if (mon_q == 5'h12) begin mon_n = 5'h01; c_yr = 1'b1; end
            else                       mon_n = mon_inc;
        end
        if (c_yr) yr_n = (yr_q == 8'h99) ? 8'h00 : yr_inc;
    end

    // Register update: advance first, then the addressed field is overwritten.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_q <= 1'b1; sec_q <= '0; min_q <= '0; hr_q <= '0;
            dow_q <= 3'd1; date_q <= 6'h01; mon_q <= 5'h01; yr_q <= '0;
        end else begin
            sec_q <= sec_n; min_q <= min_n; hr_q <= hr_n; dow_q <= dow_n;
            date_q <= date_n; mon_q <= mon_n; yr_q <= yr_n;
            if (wr_en) begin
                case (wr_addr)
                    RA_SEC:  begin halt_q <= wr_data[7]; sec_q <= wr_data[6:0]; end
                    RA_MIN:  min_q  <= wr_data[6:0];
                    RA_HR:   hr_q   <= wr_data[6:0];
                    RA_DOW:  dow_q  <= wr_data[2:0];
                    RA_DATE: date_q <= wr_data[5:0];
                    RA_MON:  mon_q  <= wr_data[4:0];
                    RA_YR:   yr_q   <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    assign halt      = halt_q;
    assign live_flat = {yr_q, 3'b0, mon_q, 2'b0, date_q, 5'b0, dow_q,
                        1'b0, hr_q, 1'b0, min_q, halt_q, sec_q};
endmodule

// File: rtl/rtc_shadow.sv
// rtc_shadow: snapshot bank of the live bytes, reloaded on a bus-start
// pulse and read by a bus interface. Addresses at or beyond NB read 0.
module rtc_shadow #(
    parameter int unsigned        NB = 7,
    parameter int unsigned        AW = 3,
    parameter logic [8*NB-1:0]    RST = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [8*NB-1:0] live_flat,
    input  logic [AW-1:0]   rd_addr,
    output logic [8*NB-1:0] shd_flat,
    output logic [7:0]      rd_data
);
    for (genvar g = 0; g < NB; g++) begin : g_byte
        // One snapshot byte: copy the live byte on load, hold otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n)    shd_flat[8*g +: 8] <= RST[8*g +: 8];
            else if (load) shd_flat[8*g +: 8] <= live_flat[8*g +: 8];
        end
    end

    // Shadow read mux with zero for unmapped addresses.
    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NB; i++)
            if (rd_addr == AW'(i)) rd_data = shd_flat[8*i +: 8];
    end
endmodule

// File: rtl/bcd_rtc_core.sv
// bcd_rtc_core: top of the BCD calendar timekeeping core. Joins the
// prescaler, counters and shadow bank. Assumes tick_en lasts one cycle
// per enable and bus_start lasts one cycle per start condition.
module bcd_rtc_core
    import rtc_pkg::*;
#(
    parameter int unsigned DIV = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [RTC_AW-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [RTC_AW-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic              bus_start,
    input  logic [RTC_AW-1:0] shd_addr,
    output logic [7:0]        shd_data,
    output logic              sec_phase,
    output logic              sec_tick
);
    logic                 halt;
    logic                 sec_wr;
    logic [RTC_FLATW-1:0] live_flat;
    logic [RTC_FLATW-1:0] shd_flat;

    assign sec_wr = wr_en && (wr_addr == RA_SEC);

    rtc_prescaler #(.DIV(DIV)) u_presc (
        .clk(clk), .rst_n(rst_n), .ce(tick_en), .halt(halt), .clr(sec_wr),
        .sec_tick(sec_tick), .phase(sec_phase)
    );

    rtc_calendar u_cal (
        .clk(clk), .rst_n(rst_n), .tick(sec_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .halt(halt), .live_flat(live_flat)
    );

    rtc_shadow #(.NB(RTC_NREGS), .AW(RTC_AW), .RST(RTC_RESET_FLAT)) u_shd (
        .clk(clk), .rst_n(rst_n), .load(bus_start), .live_flat(live_flat),
        .rd_addr(shd_addr), .shd_flat(shd_flat), .rd_data(shd_data)
    );

    // Live read mux with zero for unmapped addresses.
    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < RTC_NREGS; i++)
            if (rd_addr == RTC_AW'(i)) rd_data = live_flat[8*i +: 8];
    end
endmodule

// File: rtl/bcd_rtc_core_checker.sv
// bcd_rtc_core_checker: temporal properties of the core, bound to the top.
module bcd_rtc_core_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [2:0]  wr_addr,
    input logic [2:0]  rd_addr,
    input logic [7:0]  rd_data,
    input logic        bus_start,
    input logic        sec_tick,
    input logic        sec_phase,
    input logic [55:0] live_flat,
    input logic [55:0] shd_flat
);
    // R5: halted means no advance and frozen seconds
    a_r5_no_tick_halted: assert property (@(posedge clk) disable iff (!rst_n)
        live_flat[7] |-> !sec_tick);
    a_r5_sec_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (live_flat[7] && !wr_en) |=> $stable(live_flat[6:0]));
    // R2: seconds 59 wraps to 00 and minutes change
    a_r2_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && live_flat[6:0] == 7'h59 && !wr_en) |=>
        (live_flat[6:0] == 7'h00 && live_flat[15:8] != $past(live_flat[15:8])));
    // R6: a seconds write restarts the prescaler at its low half
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd0) |=> (!sec_phase && !sec_tick));
    // R10: shadow loads on start and holds otherwise
    a_r10_load: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> shd_flat == $past(live_flat));
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_start |=> $stable(shd_flat));
    // R11: weekday byte upper bits read zero
    a_r11_dow_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_addr == 3'd3 |-> rd_data[7:3] == 5'd0);
    // R12: unmapped address reads zero
    a_r12_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
        rd_addr == 3'd7 |-> rd_data == 8'h00);
endmodule

bind bcd_rtc_core bcd_rtc_core_checker u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .rd_addr(rd_addr), .rd_data(rd_data), .bus_start(bus_start),
    .sec_tick(sec_tick), .sec_phase(sec_phase),
    .live_flat(live_flat), .shd_flat(shd_flat)
);

// File: tb/bcd_rtc_core_bench.sv
// Scoreboard bench: driver tasks queue expected items, a monitor compares.
module bcd_rtc_core_bench;
    localparam int unsigned DIV = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0, wr_en = 1'b0, bus_start = 1'b0;
    logic [2:0] wr_addr = '0, rd_addr = '0, shd_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data, shd_data;
    logic       sec_phase, sec_tick;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    typedef struct { int kind; logic [7:0] exp; string tag; } item_t;
    item_t q[$];
    item_t mon_it;
    logic [7:0] mon_act;

    always #10 clk = ~clk;

    bcd_rtc_core #(.DIV(DIV)) u_bcd_rtc_core (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .bus_start(bus_start), .shd_addr(shd_addr), .shd_data(shd_data),
        .sec_phase(sec_phase), .sec_tick(sec_tick)
    );

    // Monitor: pop one expected item per falling edge and compare.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            mon_it = q.pop_front();
            case (mon_it.kind)
                0:       mon_act = rd_data;
                1:       mon_act = shd_data;
                default: mon_act = {7'd0, sec_phase};
            endcase
            checks++;
            if (mon_act !== mon_it.exp) begin
                fails++;
                $display("FAIL %s actual=%h expected=%h", mon_it.tag, mon_act, mon_it.exp);
            end
        end
    end

    // kind 0 live, 1 shadow, 2 phase
    task automatic expect_v(input int kind, input logic [2:0] a, input logic [7:0] e, input string tag);
        @(posedge clk); #1;
        rd_addr = a; shd_addr = a;
        q.push_back('{kind, e, tag});
        wait (q.size() == 0);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #1; wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1; wr_en = 1'b0;
    endtask

    task automatic enables(input int n);
        repeat (n) begin
            @(posedge clk); #1; tick_en = 1'b1;
            @(posedge clk); #1; tick_en = 1'b0;
        end
    endtask

    task automatic set_time(input logic [7:0] yr, mo, dt, dw, hr, mi, se);
        wr(3'd6, yr); wr(3'd5, mo); wr(3'd4, dt); wr(3'd3, dw);
        wr(3'd2, hr); wr(3'd1, mi); wr(3'd0, se);
    endtask

    task automatic start_pulse();
        @(posedge clk); #1; bus_start = 1'b1;
        @(posedge clk); #1; bus_start = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset image
        expect_v(0, 0, 8'h80, "R1 sec");  expect_v(0, 1, 8'h00, "R1 min");
        expect_v(0, 2, 8'h00, "R1 hr");   expect_v(0, 3, 8'h01, "R1 dow");
        expect_v(0, 4, 8'h01, "R1 date"); expect_v(0, 5, 8'h01, "R1 mon");
        expect_v(0, 6, 8'h00, "R1 yr");
        // R5 halted from reset
        enables(3 * DIV);
        expect_v(0, 0, 8'h80, "R5 halted sec");
        // R2 R3 R7 R8 non-leap Feb 28, 23:59:58
        set_time(8'h23, 8'h02, 8'h28, 8'h07, 8'h23, 8'h59, 8'h58);
        enables(DIV);
        expect_v(0, 0, 8'h59, "R2 sec inc"); expect_v(0, 1, 8'h59, "R2 min hold");
        enables(DIV);
        expect_v(0, 0, 8'h00, "R2 sec wrap"); expect_v(0, 1, 8'h00, "R2 min wrap");
        expect_v(0, 2, 8'h00, "R3 hr wrap");  expect_v(0, 3, 8'h01, "R8 dow 7->1");
        expect_v(0, 4, 8'h01, "R7 feb28 wrap"); expect_v(0, 5, 8'h03, "R7 month adv");
        // R7 leap February
        set_time(8'h24, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59);
        enables(DIV);
        expect_v(0, 4, 8'h29, "R7 leap 29"); expect_v(0, 3, 8'h03, "R8 dow inc");
        wr(3'd2, 8'h23); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
        enables(DIV);
        expect_v(0, 4, 8'h01, "R7 leap wrap"); expect_v(0, 5, 8'h03, "R7 leap mon");
        // R7 30-day month
        set_time(8'h24, 8'h04, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59);
        enables(DIV);
        expect_v(0, 4, 8'h01, "R7 apr30 wrap"); expect_v(0, 5, 8'h05, "R7 apr mon");
        // R9 year rollover
        set_time(8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59);
        enables(DIV);
        expect_v(0, 6, 8'h00, "R9 yr wrap"); expect_v(0, 5, 8'h01, "R9 mon wrap");
        expect_v(0, 4, 8'h01, "R9 date wrap");
        // R4 12-hour mode
        set_time(8'h10, 8'h01, 8'h05, 8'h03, 8'h51, 8'h59, 8'h59);
        enables(DIV);
        expect_v(0, 2, 8'h72, "R4 11AM->12PM"); expect_v(0, 4, 8'h05, "R4 no day adv");
        wr(3'd2, 8'h72); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
        enables(DIV);
        expect_v(0, 2, 8'h61, "R4 12PM->1PM");
        wr(3'd2, 8'h71); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
        enables(DIV);
        expect_v(0, 2, 8'h52, "R4 11PM->12AM"); expect_v(0, 4, 8'h06, "R4 day adv");
        expect_v(0, 3, 8'h04, "R4 dow adv");
        // R11 fixed zero bits
        wr(3'd0, 8'h80);
        wr(3'd1, 8'hFF); expect_v(0, 1, 8'h7F, "R11 min bit7");
        wr(3'd3, 8'hFF); expect_v(0, 3, 8'h07, "R11 dow bits");
        wr(3'd5, 8'hFF); expect_v(0, 5, 8'h1F, "R11 mon bits");
        // R12 unmapped address
        wr(3'd7, 8'hAA);
        expect_v(0, 7, 8'h00, "R12 live read"); expect_v(1, 7, 8'h00, "R12 shadow read");
        expect_v(0, 3, 8'h07, "R12 dow untouched"); expect_v(0, 6, 8'h10, "R12 yr untouched");
        // R6 prescaler clear
        wr(3'd0, 8'h10);
        enables(DIV - 3);
        wr(3'd0, 8'h10);
        enables(DIV - 1);
        expect_v(0, 0, 8'h10, "R6 no early tick");
        enables(1);
        expect_v(0, 0, 8'h11, "R6 tick at DIV");
        expect_v(2, 0, 8'h00, "R6 phase low");
        enables(DIV / 2);
        expect_v(2, 0, 8'h01, "R6 phase high");
        // R10 shadow coherence
        start_pulse();
        expect_v(1, 0, 8'h11, "R10 shadow load");
        enables(DIV / 2);
        expect_v(0, 0, 8'h12, "R10 live moved");
        expect_v(1, 0, 8'h11, "R10 shadow held");
        start_pulse();
        expect_v(1, 0, 8'h12, "R10 shadow reload");
        // R5 halt and resume
        wr(3'd0, 8'hB0);
        enables(2 * DIV);
        expect_v(0, 0, 8'hB0, "R5 halt hold");
        wr(3'd0, 8'h30);
        enables(DIV);
        expect_v(0, 0, 8'h31, "R5 resume");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog all-reqs actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule